// File: doc/BRIEF.md
# Indirect Configuration and I/O Window Port

This block gives a host a narrow register window into the configuration space and the I/O-port space of a downstream bus. Software first writes a target token into an address register. It then reads or writes one of two data windows, one for configuration space and one for I/O space. Each data window access launches exactly one downstream cycle of the matching type. The cycle carries byte enables and data steered to the correct lanes. Read data comes back right-justified once the downstream side acknowledges.

The host side is a valid/ready port. The port holds `host_ready` low while a downstream cycle is outstanding. A downstream cycle that is never acknowledged ends after a fixed timeout, and a read that times out returns all ones.

An optional mode reproduces a known bus defect. When the cycle type changes from the previous cycle, the downstream address is driven for one cycle while the type output still shows the old type. The request follows one cycle later.

Top module: `cfgw_port`

## Requirements
- R1: A host write to the address register (offset 0x064) stores the full 32-bit wdata as the token and launches no downstream cycle (`dn_drive` stays low). A read of offset 0x064 returns the token with `host_rvalid` one cycle after acceptance.
- R2: Any access to the configuration window (offset 0x068–0x06B) launches one cycle with `dn_io`=0. In that cycle `dn_addr` equals the token with bits 1:0 forced to zero, where token bits 23:16 are the bus number, 15:8 the device/function and 7:0 the register offset. `dn_req` is asserted in the cycle after acceptance and holds until `dn_ack`.
- R3: `host_size` encodes 0=byte, 1=halfword, 2 or 3=word. For the configuration window, a byte access takes its lane from window offset bits 1:0, a halfword from bit 1 (lane 0 or 2), and a word uses lane 0. `dn_be` is 0001, 0011 or 1111 shifted left by the lane, and write data is shifted left by 8×lane.
- R4: Read data is returned on `host_rdata` with `host_rvalid` one cycle after the edge that samples `dn_ack`. The data is `dn_rdata` shifted right by 8×lane and masked to the access size.
- R5: An access to the I/O window (offset 0x06C–0x06F) launches a cycle with `dn_io`=1 and `dn_addr` equal to the token unchanged. The lane comes from token bits 1:0 (bit 1 for halfword), and the window offset bits are ignored.
- R6: After reset `host_ready` is 1 and `dn_drive`, `dn_req` and `host_rvalid` are 0. From acceptance of a window access until completion, `host_ready` is 0.
- R7: A cycle not acknowledged within TIMEOUT cycles of `dn_req` (default 16) ends with `dn_req` high for exactly TIMEOUT cycles. A read that times out returns 0xFFFFFFFF.
- R8: With `early_drive_en`=1 and a cycle type different from the previous cycle, one cycle has `dn_drive`=1, `dn_req`=0, the new `dn_addr` and the previous `dn_io`. `dn_req` with the new type follows in the next cycle.
- R9: With `early_drive_en`=0, or when the type is unchanged, no early cycle occurs and `dn_req` rises in the cycle after acceptance. The type after reset counts as configuration.
- R10: Accesses to any other offset complete at once: writes change no state and start no cycle, and reads return 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| early_drive_en | input | 1 | Enables the early address drive defect mode |
| host_valid | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | HADDR_W | Host byte offset |
| host_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| host_wdata | input | 32 | Host write data, right-justified |
| host_ready | output | 1 | Port can accept an access |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 32 | Read data, right-justified |
| dn_drive | output | 1 | Downstream address being driven |
| dn_req | output | 1 | Downstream cycle request |
| dn_io | output | 1 | Cycle type: 1 I/O, 0 configuration |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream address, zero when not driven |
| dn_be | output | 4 | Downstream byte enables, zero when no request |
| dn_wdata | output | 32 | Downstream lane-steered write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The hardest situation to reach is the early-drive cycle. It appears only when the defect mode is on and the new access is of a different type from the one before it, so it depends on history that the ports do not show. The stimulus reaches it by running an I/O cycle first, then enabling the mode and issuing a configuration read. It then repeats with the same type and with the mode off to show that the extra cycle is absent. The timeout is reached by withholding `dn_ack` and counting the cycles for which `dn_req` stays high.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_ADDR = 2'd1,
        RG_CFG  = 2'd2,
        RG_IO   = 2'd3
    } region_e;

    typedef struct packed {
        logic             is_io;
        logic             we;
        logic [DW-1:0]    addr;
        logic [LANES-1:0] be;
        logic [DW-1:0]    wdata;
        acc_size_e        size;
        logic [1:0]       lane;
    } dn_cmd_t;

    function automatic logic [1:0] lane_of(acc_size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE: return off;
            SZ_HALF: return {off[1], 1'b0};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [LANES-1:0] be_of(acc_size_e sz, logic [1:0] lane);
        case (sz)
            SZ_BYTE: return 4'b0001 << lane;
            SZ_HALF: return 4'b0011 << lane;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DW-1:0] place(logic [DW-1:0] d, logic [1:0] lane);
        return d << {lane, 3'b000};
    endfunction

    function automatic logic [DW-1:0] extract(logic [DW-1:0] d, acc_size_e sz,
                                              logic [1:0] lane);
        logic [DW-1:0] t;
        t = d >> {lane, 3'b000};
        case (sz)
            SZ_BYTE: return {24'h0, t[7:0]};
            SZ_HALF: return {16'h0, t[15:0]};
            default: return t;
        endcase
    endfunction

endpackage

// File: rtl/cfgw_cmd_build.sv
module cfgw_cmd_build
    import cfgw_pkg::*;
(
    input  region_e       region,
    input  logic          we,
    input  logic [1:0]    size,
    input  logic [1:0]    win_off,
    input  logic [DW-1:0] token,
    input  logic [DW-1:0] wdata,
    output dn_cmd_t       cmd
);
    acc_size_e  sz;
    logic [1:0] lane;
    logic       io_sel;

    always_comb begin
        sz     = acc_size_e'(size);
        io_sel = (region == RG_IO);
        // configuration lanes follow the window offset, I/O lanes the port address
        lane   = io_sel ? lane_of(sz, token[1:0]) : lane_of(sz, win_off);
        cmd.is_io = io_sel;
        cmd.we    = we;
        cmd.addr  = io_sel ? token : {token[DW-1:2], 2'b00};
        cmd.be    = be_of(sz, lane);
        cmd.wdata = place(wdata, lane);
        cmd.size  = sz;
        cmd.lane  = lane;
    end
endmodule

// File: rtl/cfgw_cycle_seq.sv
module cfgw_cycle_seq
    import cfgw_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             start,
    input  dn_cmd_t          cmd_i,
    output logic             busy,
    output logic             rvalid,
    output logic [DW-1:0]    rdata,
    output logic             dn_drive,
    output logic             dn_req,
    output logic             dn_io,
    output logic             dn_we,
    output logic [DW-1:0]    dn_addr,
    output logic [LANES-1:0] dn_be,
    output logic [DW-1:0]    dn_wdata,
    input  logic             dn_ack,
    input  logic [DW-1:0]    dn_rdata
);
    localparam int             CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    typedef enum logic [1:0] {S_IDLE, S_PRE, S_ISSUE} seq_state_e;

    seq_state_e       state;
    dn_cmd_t          cmd_q;
    logic             type_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cmd_q  <= '0;
            type_q <= 1'b0;
            cnt    <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        cmd_q <= cmd_i;
                        cnt   <= '0;
                        if (step_en && (cmd_i.is_io != type_q)) begin
                            state <= S_PRE;
                        end else begin
                            state  <= S_ISSUE;
                            type_q <= cmd_i.is_io;
                        end
                    end
                end
                S_PRE: begin
                    state  <= S_ISSUE;
                    type_q <= cmd_q.is_io;
                end
                S_ISSUE: begin
                    if (dn_ack) begin
                        state  <= S_IDLE;
                        rvalid <= !cmd_q.we;
                        rdata  <= extract(dn_rdata, cmd_q.size, cmd_q.lane);
                    end else if (cnt == LAST) begin
                        state  <= S_IDLE;
                        rvalid <= !cmd_q.we;
                        rdata  <= '1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != S_IDLE);
        dn_drive = (state != S_IDLE);
        dn_req   = (state == S_ISSUE);
        dn_io    = type_q;
        dn_we    = dn_req && cmd_q.we;
        dn_addr  = dn_drive ? cmd_q.addr : '0;
        dn_be    = dn_req ? cmd_q.be : '0;
        dn_wdata = dn_req ? cmd_q.wdata : '0;
    end

    // R8: an early-drive cycle is always followed by the request
    a_r8_pre_then_req: assert property (@(posedge clk) disable iff (rst)
        (dn_drive && !dn_req) |=> dn_req);
    // R8: the type output switches as the request follows the early cycle
    a_r8_type_switches: assert property (@(posedge clk) disable iff (rst)
        (dn_drive && !dn_req) |=> (dn_io != $past(dn_io)));
    // R2: the address is steady while a request is held
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        dn_req |=> (!dn_req || $stable(dn_addr)));
    // R7: the wait counter never passes the timeout bound
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R3: byte enables are never empty and never three lanes
    a_r3_be_shape: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> (dn_be != '0 && $countones(dn_be) != 3));
endmodule

// File: rtl/cfgw_port.sv
module cfgw_port
    import cfgw_pkg::*;
#(
    parameter int HADDR_W  = 12,
    parameter int OFF_ADDR = 'h064,
    parameter int OFF_CFG  = 'h068,
    parameter int OFF_IO   = 'h06C,
    parameter int TIMEOUT  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               early_drive_en,
    input  logic               host_valid,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [1:0]         host_size,
    input  logic [31:0]        host_wdata,
    output logic               host_ready,
    output logic               host_rvalid,
    output logic [31:0]        host_rdata,
    output logic               dn_drive,
    output logic               dn_req,
    output logic               dn_io,
    output logic               dn_we,
    output logic [31:0]        dn_addr,
    output logic [3:0]         dn_be,
    output logic [31:0]        dn_wdata,
    input  logic               dn_ack,
    input  logic [31:0]        dn_rdata
);
    localparam logic [HADDR_W-1:0] A_ADDR = HADDR_W'(OFF_ADDR);
    localparam logic [HADDR_W-1:0] A_CFG  = HADDR_W'(OFF_CFG);
    localparam logic [HADDR_W-1:0] A_IO   = HADDR_W'(OFF_IO);

    region_e       region;
    logic          accept;
    logic          start;
    logic          busy;
    logic [DW-1:0] token_q;
    logic          reg_rvalid_q;
    logic [DW-1:0] reg_rdata_q;
    logic          seq_rvalid;
    logic [DW-1:0] seq_rdata;
    dn_cmd_t       cmd;

    always_comb begin
        if (host_addr[HADDR_W-1:2] == A_ADDR[HADDR_W-1:2])     region = RG_ADDR;
        else if (host_addr[HADDR_W-1:2] == A_CFG[HADDR_W-1:2]) region = RG_CFG;
        else if (host_addr[HADDR_W-1:2] == A_IO[HADDR_W-1:2])  region = RG_IO;
        else                                                   region = RG_NONE;
        host_ready = !busy;
        accept     = host_valid && host_ready;
        start      = accept && (region == RG_CFG || region == RG_IO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            token_q      <= '0;
            reg_rvalid_q <= 1'b0;
            reg_rdata_q  <= '0;
        end else begin
            reg_rvalid_q <= 1'b0;
            if (accept && region == RG_ADDR) begin
                if (host_we) token_q <= host_wdata;
                else begin
                    reg_rvalid_q <= 1'b1;
                    reg_rdata_q  <= token_q;
                end
            end else if (accept && region == RG_NONE && !host_we) begin
                reg_rvalid_q <= 1'b1;
                reg_rdata_q  <= '0;
            end
        end
    end

    cfgw_cmd_build u_build (
        .region  (region),
        .we      (host_we),
        .size    (host_size),
        .win_off (host_addr[1:0]),
        .token   (token_q),
        .wdata   (host_wdata),
        .cmd     (cmd)
    );

    cfgw_cycle_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .step_en  (early_drive_en),
        .start    (start),
        .cmd_i    (cmd),
        .busy     (busy),
        .rvalid   (seq_rvalid),
        .rdata    (seq_rdata),
        .dn_drive (dn_drive),
        .dn_req   (dn_req),
        .dn_io    (dn_io),
        .dn_we    (dn_we),
        .dn_addr  (dn_addr),
        .dn_be    (dn_be),
        .dn_wdata (dn_wdata),
        .dn_ack   (dn_ack),
        .dn_rdata (dn_rdata)
    );

    always_comb begin
        host_rvalid = reg_rvalid_q || seq_rvalid;
        host_rdata  = seq_rvalid ? seq_rdata : reg_rdata_q;
    end

    // R6: the host is stalled whenever the downstream side is driven
    a_r6_stall: assert property (@(posedge clk) disable iff (rst)
        dn_drive |-> !host_ready);
    // R2: configuration addresses are dword aligned
    a_r2_cfg_align: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_io) |-> (dn_addr[1:0] == 2'b00));
    // R1: an address-register access starts no downstream activity
    a_r1_no_cycle: assert property (@(posedge clk) disable iff (rst)
        (accept && region == RG_ADDR) |=> !dn_drive);
    // R10: an unmapped access starts no downstream activity
    a_r10_no_cycle: assert property (@(posedge clk) disable iff (rst)
        (accept && region == RG_NONE) |=> !dn_drive);
endmodule

// File: tb/cfgw_port_tb_top.sv
module cfgw_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        early_drive_en;
    logic        host_valid, host_we;
    logic [11:0] host_addr;
    logic [1:0]  host_size;
    logic [31:0] host_wdata;
    logic        host_ready, host_rvalid;
    logic [31:0] host_rdata;
    logic        dn_drive, dn_req, dn_io, dn_we;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be;
    logic        dn_ack;
    logic [31:0] dn_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgw_port #(.TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst(rst), .early_drive_en(early_drive_en),
        .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .dn_drive(dn_drive), .dn_req(dn_req), .dn_io(dn_io), .dn_we(dn_we),
        .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // drives one host access at a negedge; returns at the negedge after acceptance
    task automatic host_acc(logic we, logic [11:0] a, logic [1:0] sz, logic [31:0] wd);
        @(negedge clk);
        host_valid = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    // acknowledges at the current negedge; returns at the next negedge
    task automatic ack_now(logic [31:0] rd);
        dn_ack = 1'b1; dn_rdata = rd;
        @(negedge clk);
        dn_ack = 1'b0;
    endtask

    task automatic t_reset;
        check("R6", "ready after reset", {31'h0, host_ready}, 32'h1);
        check("R6", "drive after reset", {31'h0, dn_drive}, 32'h0);
        check("R6", "req after reset",   {31'h0, dn_req}, 32'h0);
        check("R6", "rvalid after reset", {31'h0, host_rvalid}, 32'h0);
    endtask

    task automatic t_addr_reg;
        host_acc(1'b1, 12'h064, 2'd2, 32'h0012_345B);
        check("R1", "no drive after token write", {31'h0, dn_drive}, 32'h0);
        host_acc(1'b0, 12'h064, 2'd2, 32'h0);
        check("R1", "token readback valid", {31'h0, host_rvalid}, 32'h1);
        check("R1", "token readback", host_rdata, 32'h0012_345B);
    endtask

    task automatic t_cfg_word_read;
        host_acc(1'b0, 12'h068, 2'd2, 32'h0);
        check("R2", "cfg req", {31'h0, dn_req}, 32'h1);
        check("R2", "cfg type", {31'h0, dn_io}, 32'h0);
        check("R2", "cfg aligned addr", dn_addr, 32'h0012_3458);
        check("R3", "word be", {28'h0, dn_be}, 32'hF);
        check("R6", "ready low while busy", {31'h0, host_ready}, 32'h0);
        repeat (3) @(negedge clk);
        check("R2", "req held", {31'h0, dn_req}, 32'h1);
        ack_now(32'hCAFE_F00D);
        check("R4", "word read valid", {31'h0, host_rvalid}, 32'h1);
        check("R4", "word read data", host_rdata, 32'hCAFE_F00D);
        check("R6", "ready back", {31'h0, host_ready}, 32'h1);
        check("R2", "req dropped", {31'h0, dn_req}, 32'h0);
    endtask

    task automatic t_cfg_byte_write;
        host_acc(1'b1, 12'h06A, 2'd0, 32'h0000_00A5);
        check("R3", "byte lane2 be", {28'h0, dn_be}, 32'h4);
        check("R3", "byte lane2 wdata", dn_wdata, 32'h00A5_0000);
        check("R3", "write flag", {31'h0, dn_we}, 32'h1);
        ack_now(32'h0);
        check("R4", "no rvalid on write", {31'h0, host_rvalid}, 32'h0);
    endtask

    task automatic t_cfg_sub_reads;
        host_acc(1'b0, 12'h06B, 2'd1, 32'h0);
        check("R3", "half at offset 3 be", {28'h0, dn_be}, 32'hC);
        ack_now(32'h1234_ABCD);
        check("R4", "half read data", host_rdata, 32'h0000_1234);
        host_acc(1'b0, 12'h069, 2'd0, 32'h0);
        check("R3", "byte lane1 be", {28'h0, dn_be}, 32'h2);
        ack_now(32'h1234_ABCD);
        check("R4", "byte read data", host_rdata, 32'h0000_00AB);
    endtask

    task automatic t_io;
        host_acc(1'b1, 12'h064, 2'd2, 32'h0000_0301);
        host_acc(1'b0, 12'h06C, 2'd0, 32'h0);
        check("R9", "io req without early cycle", {31'h0, dn_req}, 32'h1);
        check("R5", "io type", {31'h0, dn_io}, 32'h1);
        check("R5", "io addr unchanged", dn_addr, 32'h0000_0301);
        check("R5", "io byte be from port", {28'h0, dn_be}, 32'h2);
        ack_now(32'h0000_5A00);
        check("R5", "io byte read", host_rdata, 32'h0000_005A);
        host_acc(1'b0, 12'h06F, 2'd0, 32'h0);
        check("R5", "window offset ignored", {28'h0, dn_be}, 32'h2);
        ack_now(32'h0);
        host_acc(1'b1, 12'h064, 2'd2, 32'h0000_0302);
        host_acc(1'b1, 12'h06C, 2'd1, 32'h0000_BEEF);
        check("R5", "io half be", {28'h0, dn_be}, 32'hC);
        check("R5", "io half wdata", dn_wdata, 32'hBEEF_0000);
        ack_now(32'h0);
    endtask

    task automatic t_step;
        int n;
        host_acc(1'b1, 12'h064, 2'd2, 32'h0001_0810);
        early_drive_en = 1'b1;
        host_acc(1'b0, 12'h068, 2'd2, 32'h0);
        check("R8", "early drive", {31'h0, dn_drive}, 32'h1);
        check("R8", "no req in early cycle", {31'h0, dn_req}, 32'h0);
        check("R8", "old type in early cycle", {31'h0, dn_io}, 32'h1);
        check("R8", "new addr in early cycle", dn_addr, 32'h0001_0810);
        @(negedge clk);
        check("R8", "req after early cycle", {31'h0, dn_req}, 32'h1);
        check("R8", "new type with req", {31'h0, dn_io}, 32'h0);
        ack_now(32'h0000_1111);
        check("R8", "read completes", host_rdata, 32'h0000_1111);
        host_acc(1'b0, 12'h068, 2'd2, 32'h0);
        check("R9", "same type no early cycle", {31'h0, dn_req}, 32'h1);
        ack_now(32'h0);
        early_drive_en = 1'b0;
        host_acc(1'b0, 12'h06C, 2'd2, 32'h0);
        check("R9", "mode off type change", {31'h0, dn_req}, 32'h1);
        check("R9", "mode off new type", {31'h0, dn_io}, 32'h1);
        ack_now(32'h0);
        n = 0;
        host_acc(1'b0, 12'h068, 2'd2, 32'h0);
        while (dn_req && n < 100) begin n++; @(negedge clk); end
        check("R7", "timeout length", n, TMO);
        check("R7", "timeout rvalid", {31'h0, host_rvalid}, 32'h1);
        check("R7", "timeout all ones", host_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped;
        host_acc(1'b1, 12'h070, 2'd2, 32'hDEAD_BEEF);
        check("R10", "no drive on unmapped write", {31'h0, dn_drive}, 32'h0);
        host_acc(1'b0, 12'h064, 2'd2, 32'h0);
        check("R10", "token untouched", host_rdata, 32'h0001_0810);
        host_acc(1'b0, 12'h070, 2'd2, 32'h0);
        check("R10", "unmapped read valid", {31'h0, host_rvalid}, 32'h1);
        check("R10", "unmapped read zero", host_rdata, 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; early_drive_en = 1'b0; host_valid = 1'b0; host_we = 1'b0;
        host_addr = '0; host_size = 2'd2; host_wdata = '0; dn_ack = 1'b0; dn_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_addr_reg;
        t_cfg_word_read;
        t_cfg_byte_write;
        t_cfg_sub_reads;
        t_io;
        t_step;
        t_unmapped;
        repeat (2) @(negedge clk);
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule